// File: doc/BRIEF.md
# Extension Register Load/Store Sequencer

This block steps a coprocessor load/store instruction through the words it moves between memory and the extension register file. When an instruction is accepted it is sorted into one of four kinds: a single-register transfer, a stack push, a stack pop or a general multiple transfer. From that kind it works out the first register-file word, how many words move and whether the base register is written back, and with what value. A setup cycle follows, in which the base write-back is offered to the core. After that, each beat strobe from the core moves one 32-bit word. The block drives the register-file word index and answers each beat with either "increment" (more words follow) or "done".

On a store the word read from the register file is returned to the core as store data. On a load the word from the core is written into the register file. Loads also accept a transfer-phase strobe, which is answered "done" and changes nothing. The block does not generate memory addresses, check alignment or reorder bytes.

Top module: `xreg_xfer_seq`

## Requirements
- R1: Instruction fields are P=bit 24, U=bit 23, D=bit 22, W=bit 21, L=bit 20 (1 = load), Rn=bits 19:16, Vd=bits 15:12, precision=bit 8 (0 = single), imm8=bits 7:0. The kind code on `kind_o` is 0 for single transfer (P=1, W=0), 1 for push (store, P=1, U=0, W=1, Rn=13), 2 for pop (load, P=0, U=1, W=1, Rn=13) and 3 for all other patterns. It is valid while `busy_o` is high.
- R2: For single precision the first word index is Vd*2+D. For double precision it is (D*16+Vd)*2.
- R3: The word count is 1 for a single-precision single transfer and 2 for a double-precision single transfer. Otherwise it is imm8 for single precision and imm8 with bit 0 cleared for double precision.
- R4: In the setup cycle (the cycle after acceptance) `wb_valid_o` pulses when a write-back applies. A push writes register 13 with base minus imm8*4. A pop writes register 13 with base plus imm8*4. A multiple transfer with W=1 writes Rn with base plus imm8*4 when U=1 and base minus imm8*4 when U=0. A single transfer never writes back, and `wb_valid_o` is low in every other cycle.
- R5: Data beats use word indices from the first index upward, one per beat, modulo 64.
- R6: A beat is answered with `resp_inc_o` while words remain after it, and with `resp_done_o` on the last word.
- R7: On a store, `st_data_o` carries the register-file word at `rf_idx_o`. On a load beat, `rf_we_o` writes `ld_data_i` to `rf_idx_o`.
- R8: During the data phase of a load, a transfer strobe with no beat is answered with `resp_done_o` and writes nothing. The word index does not advance. On a store the strobe gets no answer.
- R9: A start while busy raises `reject_o` in that cycle and does not disturb the instruction in progress.
- R10: A word count of zero returns the block to idle directly after the setup cycle.
- R11: Beats and strobes while idle or in setup get no answer and cause no register-file write.
- R12: After reset the block is idle, with no response, no write-back and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | New instruction strobe |
| instr_i | input | 32 | Instruction word |
| base_val_i | input | 32 | Current value of the base register named by the instruction |
| beat_i | input | 1 | Data beat strobe |
| xfer_i | input | 1 | Transfer-phase strobe (loads) |
| ld_data_i | input | 32 | Word from memory on a load beat |
| rf_rdata_i | input | 32 | Register-file read data at `rf_idx_o` |
| busy_o | output | 1 | Instruction in progress |
| reject_o | output | 1 | Start refused because busy |
| kind_o | output | 2 | Instruction kind code |
| wb_valid_o | output | 1 | Base write-back strobe |
| wb_reg_o | output | 4 | Base register to update |
| wb_val_o | output | 32 | New base value |
| rf_idx_o | output | 6 | Register-file word index |
| rf_we_o | output | 1 | Register-file write enable |
| rf_wdata_o | output | 32 | Register-file write data |
| st_data_o | output | 32 | Store data to the core |
| resp_inc_o | output | 1 | Beat answer: more words follow |
| resp_done_o | output | 1 | Beat or strobe answer: finished |

## Verification
The hardest cases are the classification corner cases. A push pattern without register 13, or the pop pattern on a store, must fall through to a general multiple transfer with the same write-back arithmetic. Both can only be told apart at the kind port. The stimulus sweeps every P/U/W combination against both a stack and a non-stack base register, for both directions and both precisions, with counts that include zero and an odd double-precision immediate. Reject, strobe and ignored-beat checks are placed inside the setup and first data cycles of those same instructions, so they meet live state.

// File: rtl/xseq_pkg.sv
package xseq_pkg;
   typedef enum logic [1:0] {
      XK_SINGLE = 2'd0,
      XK_PUSH   = 2'd1,
      XK_POP    = 2'd2,
      XK_MULTI  = 2'd3
   } xfer_kind_e;

   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_SETUP = 2'd1,
      XS_DATA  = 2'd2
   } xseq_state_e;

   localparam int INSTR_W = 32;
   localparam int REGN_W  = 4;
   localparam int IMM_W   = 8;
endpackage

// File: rtl/xseq_decode.sv
module xseq_decode
   import xseq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 6,
   parameter int CNT_W  = 9,
   parameter int SP_REG = 13
) (
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  base_i,
   output xfer_kind_e         kind_o,
   output logic               load_o,
   output logic [IDX_W-1:0]   first_o,
   output logic [CNT_W-1:0]   words_o,
   output logic               wb_en_o,
   output logic [REGN_W-1:0]  wb_reg_o,
   output logic [DATA_W-1:0]  wb_val_o
);
   localparam int SGL_IDX_W = 5;
   localparam int DBL_IDX_W = 6;

   logic              f_p, f_u, f_d, f_w, f_l, f_sgl, sp_base;
   logic [REGN_W-1:0] f_rn, f_vd;
   logic [IMM_W-1:0]  f_imm;
   logic [DATA_W-1:0] offset, sum_up, sum_dn;

   assign f_p     = instr_i[24];
   assign f_u     = instr_i[23];
   assign f_d     = instr_i[22];
   assign f_w     = instr_i[21];
   assign f_l     = instr_i[20];
   assign f_rn    = instr_i[19:16];
   assign f_vd    = instr_i[15:12];
   assign f_sgl   = ~instr_i[8];
   assign f_imm   = instr_i[7:0];
   assign sp_base = (f_rn == REGN_W'(SP_REG));
   assign load_o  = f_l;

   assign offset = DATA_W'({f_imm, 2'b00});
   assign sum_up = base_i + offset;
   assign sum_dn = base_i - offset;

   always_comb begin
      if (f_p && !f_w)
         kind_o = XK_SINGLE;
      else if (!f_l && f_p && !f_u && f_w && sp_base)
         kind_o = XK_PUSH;
      else if (f_l && !f_p && f_u && f_w && sp_base)
         kind_o = XK_POP;
      else
         kind_o = XK_MULTI;
   end

   // first word index, zero-extended to the register-file index width
   logic [SGL_IDX_W-1:0] sgl_first;
   logic [DBL_IDX_W-1:0] dbl_first;
   assign sgl_first = {f_vd, f_d};
   assign dbl_first = {f_d, f_vd, 1'b0};

   generate
      if (IDX_W == DBL_IDX_W) begin : g_idx_exact
         assign first_o = f_sgl ? {1'b0, sgl_first} : dbl_first;
      end else begin : g_idx_wide
         assign first_o = f_sgl ? IDX_W'(sgl_first) : IDX_W'(dbl_first);
      end
   endgenerate

   always_comb begin
      if (kind_o == XK_SINGLE)
         words_o = f_sgl ? CNT_W'(1) : CNT_W'(2);
      else if (f_sgl)
         words_o = CNT_W'(f_imm);
      else
         words_o = CNT_W'({f_imm[IMM_W-1:1], 1'b0});
   end

   always_comb begin
      wb_en_o  = 1'b0;
      wb_reg_o = f_rn;
      wb_val_o = base_i;
      unique case (kind_o)
         XK_PUSH: begin
            wb_en_o  = 1'b1;
            wb_reg_o = REGN_W'(SP_REG);
            wb_val_o = sum_dn;
         end
         XK_POP: begin
            wb_en_o  = 1'b1;
            wb_reg_o = REGN_W'(SP_REG);
            wb_val_o = sum_up;
         end
         XK_MULTI: begin
            wb_en_o  = f_w;
            wb_val_o = f_u ? sum_up : sum_dn;
         end
         default: wb_en_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/xseq_wordctr.sv
module xseq_wordctr #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic [CNT_W-1:0] total_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             last_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (clr_i)
         cnt_o <= '0;
      else if (adv_i)
         cnt_o <= cnt_o + 1'b1;
   end

   assign last_o = ((cnt_o + 1'b1) == total_i);

   // R3
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adv_i |-> (cnt_o < total_i));
endmodule

// File: rtl/xreg_xfer_seq.sv
module xreg_xfer_seq
   import xseq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 6,
   parameter int SP_REG = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [31:0]       instr_i,
   input  logic [DATA_W-1:0] base_val_i,
   input  logic              beat_i,
   input  logic              xfer_i,
   input  logic [DATA_W-1:0] ld_data_i,
   input  logic [DATA_W-1:0] rf_rdata_i,
   output logic              busy_o,
   output logic              reject_o,
   output logic [1:0]        kind_o,
   output logic              wb_valid_o,
   output logic [3:0]        wb_reg_o,
   output logic [DATA_W-1:0] wb_val_o,
   output logic [IDX_W-1:0]  rf_idx_o,
   output logic              rf_we_o,
   output logic [DATA_W-1:0] rf_wdata_o,
   output logic [DATA_W-1:0] st_data_o,
   output logic              resp_inc_o,
   output logic              resp_done_o
);
   localparam int CNT_W = IMM_W + 1;

   generate
      if (DATA_W < 32) begin : g_bad_data_w
         $error("DATA_W must hold a full address word");
      end
      if (IDX_W < 6) begin : g_bad_idx_w
         $error("IDX_W must cover 64 register-file words");
      end
      if (SP_REG < 0 || SP_REG > 15) begin : g_bad_sp
         $error("SP_REG must name one of 16 core registers");
      end
   endgenerate

   xseq_state_e       state_q;
   xfer_kind_e        dec_kind, kind_q;
   logic              dec_load, load_q;
   logic [IDX_W-1:0]  dec_first, first_q;
   logic [CNT_W-1:0]  dec_words, words_q, cnt;
   logic              dec_wb_en, wb_en_q;
   logic [3:0]        dec_wb_reg, wb_reg_q;
   logic [DATA_W-1:0] dec_wb_val, wb_val_q;
   logic              accept, in_data, beat_ok, last;

   xseq_decode #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .SP_REG(SP_REG)
   ) u_dec (
      .instr_i  (instr_i),
      .base_i   (base_val_i),
      .kind_o   (dec_kind),
      .load_o   (dec_load),
      .first_o  (dec_first),
      .words_o  (dec_words),
      .wb_en_o  (dec_wb_en),
      .wb_reg_o (dec_wb_reg),
      .wb_val_o (dec_wb_val)
   );

   assign accept  = start_i && (state_q == XS_IDLE);
   assign in_data = (state_q == XS_DATA);
   assign beat_ok = in_data && beat_i;

   xseq_wordctr #(.CNT_W(CNT_W)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (accept),
      .adv_i   (beat_ok),
      .total_i (words_q),
      .cnt_o   (cnt),
      .last_o  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q   <= XK_SINGLE;
         load_q   <= 1'b0;
         first_q  <= '0;
         words_q  <= '0;
         wb_en_q  <= 1'b0;
         wb_reg_q <= '0;
         wb_val_q <= '0;
      end else if (accept) begin
         kind_q   <= dec_kind;
         load_q   <= dec_load;
         first_q  <= dec_first;
         words_q  <= dec_words;
         wb_en_q  <= dec_wb_en;
         wb_reg_q <= dec_wb_reg;
         wb_val_q <= dec_wb_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= XS_IDLE;
      else begin
         unique case (state_q)
            XS_IDLE:  if (accept) state_q <= XS_SETUP;
            XS_SETUP: state_q <= (words_q == '0) ? XS_IDLE : XS_DATA;
            XS_DATA:  if (beat_i && last) state_q <= XS_IDLE;
            default:  state_q <= XS_IDLE;
         endcase
      end
   end

   assign busy_o      = (state_q != XS_IDLE);
   assign reject_o    = start_i && busy_o;
   assign kind_o      = kind_q;
   assign wb_valid_o  = (state_q == XS_SETUP) && wb_en_q;
   assign wb_reg_o    = wb_reg_q;
   assign wb_val_o    = wb_val_q;
   assign rf_idx_o    = first_q + IDX_W'(cnt);
   assign rf_we_o     = beat_ok && load_q;
   assign rf_wdata_o  = ld_data_i;
   assign st_data_o   = rf_rdata_i;
   assign resp_inc_o  = beat_ok && !last;
   assign resp_done_o = (beat_ok && last) || (in_data && !beat_i && xfer_i && load_q);

   // R4
   wb_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid_o |-> $past(start_i && !busy_o));
   // R5
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_inc_o |=> (rf_idx_o == IDX_W'($past(rf_idx_o) + 1'b1)));
   // R6
   done_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_i && resp_done_o) |=> !busy_o);
   // R8
   strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && xfer_i && !beat_i) |=> $stable(rf_idx_o));
   // R9
   reject_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reject_o |=> $stable(kind_o));
   // R11
   write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> (busy_o && !wb_valid_o));
endmodule

// File: tb/xreg_xfer_seq_bench.sv
module xreg_xfer_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] base_val_i = '0;
   logic        beat_i = 1'b0;
   logic        xfer_i = 1'b0;
   logic [31:0] ld_data_i = '0;
   logic [31:0] rf_rdata_i;
   logic        busy_o, reject_o, wb_valid_o, rf_we_o, resp_inc_o, resp_done_o;
   logic [1:0]  kind_o;
   logic [3:0]  wb_reg_o;
   logic [31:0] wb_val_o, rf_wdata_o, st_data_o;
   logic [5:0]  rf_idx_o;

   logic [31:0] mem [64];
   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   assign rf_rdata_i = mem[rf_idx_o];

   xreg_xfer_seq u_xreg_xfer_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
      .base_val_i(base_val_i), .beat_i(beat_i), .xfer_i(xfer_i),
      .ld_data_i(ld_data_i), .rf_rdata_i(rf_rdata_i), .busy_o(busy_o),
      .reject_o(reject_o), .kind_o(kind_o), .wb_valid_o(wb_valid_o),
      .wb_reg_o(wb_reg_o), .wb_val_o(wb_val_o), .rf_idx_o(rf_idx_o),
      .rf_we_o(rf_we_o), .rf_wdata_o(rf_wdata_o), .st_data_o(st_data_o),
      .resp_inc_o(resp_inc_o), .resp_done_o(resp_done_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      finish_run();
   end

   // expected model built from the requirements
   task automatic model(input logic [31:0] ins, input logic [31:0] base,
                        output int kind, output int first, output int words,
                        output bit wb, output int wreg, output logic [31:0] wval);
      bit p = ins[24], u = ins[23], d = ins[22], w = ins[21], l = ins[20];
      int rn = int'(ins[19:16]);
      int vd = int'(ins[15:12]);
      bit sgl = !ins[8];
      int imm = int'(ins[7:0]);
      if (p && !w) kind = 0;
      else if (!l && p && !u && w && rn == 13) kind = 1;
      else if (l && !p && u && w && rn == 13) kind = 2;
      else kind = 3;
      first = sgl ? (vd * 2 + int'(d)) : ((int'(d) * 16 + vd) * 2);
      if (kind == 0) words = sgl ? 1 : 2;
      else words = sgl ? imm : (imm / 2) * 2;
      wb = 0; wreg = rn; wval = base;
      case (kind)
         1: begin wb = 1; wreg = 13; wval = base - 32'(imm * 4); end
         2: begin wb = 1; wreg = 13; wval = base + 32'(imm * 4); end
         3: begin wb = w; wval = u ? base + 32'(imm * 4) : base - 32'(imm * 4); end
         default: wb = 0;
      endcase
   endtask

   task automatic run_instr(input logic [31:0] ins, input logic [31:0] base,
                            input bit try_reject, input bit try_strobe);
      int kind, first, words, wreg;
      bit wb;
      logic [31:0] wval;
      bit ld = ins[20];
      model(ins, base, kind, first, words, wb, wreg, wval);
      for (int i = 0; i < 64; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0101_0003) ^ base;

      @(negedge clk);
      start_i = 1'b1; instr_i = ins; base_val_i = base;
      #1;
      check("R9 idle start not rejected", {31'd0, reject_o}, 32'd0);
      @(negedge clk);
      start_i = 1'b0;
      beat_i = 1'b1; xfer_i = 1'b1;        // ignored in setup
      #1;
      check("R1 kind", {30'd0, kind_o}, kind);
      check("R4 wb_valid", {31'd0, wb_valid_o}, {31'd0, wb});
      if (wb) begin
         check("R4 wb_reg", {28'd0, wb_reg_o}, wreg);
         check("R4 wb_val", wb_val_o, wval);
      end
      check("R11 setup beat ignored", {29'd0, resp_inc_o, resp_done_o, rf_we_o}, 32'd0);
      @(negedge clk);
      beat_i = 1'b0; xfer_i = 1'b0;
      #1;
      if (words == 0) begin
         check("R10 zero count idle", {31'd0, busy_o}, 32'd0);
         check("R4 wb_valid after setup", {31'd0, wb_valid_o}, 32'd0);
         return;
      end
      check("R2 first index", {26'd0, rf_idx_o}, first);
      if (try_strobe) begin
         xfer_i = 1'b1;
         #1;
         check("R8 strobe answer", {30'd0, resp_inc_o, resp_done_o}, ld ? 32'd1 : 32'd0);
         check("R8 strobe no write", {31'd0, rf_we_o}, 32'd0);
         @(negedge clk);
         xfer_i = 1'b0;
         #1;
         check("R8 index held", {26'd0, rf_idx_o}, first);
      end
      for (int k = 0; k < words; k++) begin
         int idx = (first + k) % 64;
         beat_i = 1'b1;
         ld_data_i = 32'h5C00_0000 + (k << 8) + base[15:0];
         if (try_reject && k == 0) begin
            start_i = 1'b1;
            instr_i = ins ^ 32'h0120_0000;
         end
         #1;
         check("R5 word index", {26'd0, rf_idx_o}, idx);
         check("R6 response", {30'd0, resp_inc_o, resp_done_o},
               (k == words - 1) ? 32'd1 : 32'd2);
         if (try_reject && k == 0)
            check("R9 reject while busy", {31'd0, reject_o}, 32'd1);
         if (ld) begin
            check("R7 load write enable", {31'd0, rf_we_o}, 32'd1);
            check("R7 load write data", rf_wdata_o, ld_data_i);
            if (rf_we_o) mem[rf_idx_o] = rf_wdata_o;
         end else begin
            check("R7 store no write", {31'd0, rf_we_o}, 32'd0);
            check("R7 store data", st_data_o, 32'hA500_0000 ^ (idx * 32'h0101_0003) ^ base);
         end
         @(negedge clk);
         start_i = 1'b0;
         if (try_reject && k == 0) begin
            #1;
            check("R9 kind kept", {30'd0, kind_o}, kind);
         end
      end
      beat_i = 1'b0;
      #1;
      check("R6 idle after done", {31'd0, busy_o}, 32'd0);
      if (ld)
         for (int k = 0; k < words; k++)
            check("R7 loaded word", mem[(first + k) % 64],
                  32'h5C00_0000 + (k << 8) + base[15:0]);
   endtask

   initial begin
      int iter = 0;
      int imms [5] = '{0, 1, 2, 3, 7};
      repeat (3) @(negedge clk);
      #1;
      check("R12 reset busy", {31'd0, busy_o}, 32'd0);
      check("R12 reset outputs", {28'd0, wb_valid_o, rf_we_o, resp_inc_o, resp_done_o}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      beat_i = 1'b1; xfer_i = 1'b1;
      #1;
      check("R11 idle beat ignored", {29'd0, resp_inc_o, resp_done_o, rf_we_o}, 32'd0);
      @(negedge clk);
      beat_i = 1'b0; xfer_i = 1'b0;
      #1;
      check("R11 idle stays idle", {31'd0, busy_o}, 32'd0);

      for (int prec = 0; prec < 2; prec++)
         for (int ld = 0; ld < 2; ld++)
            for (int puw = 0; puw < 8; puw++)
               for (int rs = 0; rs < 2; rs++)
                  for (int ii = 0; ii < 5; ii++) begin
                     logic [31:0] ins = '0;
                     ins[24] = puw[2];
                     ins[23] = puw[1];
                     ins[21] = puw[0];
                     ins[22] = iter[0];
                     ins[20] = ld[0];
                     ins[19:16] = rs ? 4'd13 : 4'(5 + (iter % 3));
                     ins[15:12] = 4'(iter % 8);
                     ins[11:9] = 3'b101;
                     ins[8] = prec[0];
                     ins[7:0] = 8'(imms[ii]);
                     run_instr(ins, 32'h1000_0000 + 32'(iter * 32'h40),
                               (iter % 3) == 0, (iter % 2) == 1);
                     iter++;
                  end
      @(negedge clk);
      finish_run();
   end
endmodule